// File: doc/BRIEF.md
# Two-Level Rotating Bus Arbiter

This block is the central arbiter of a shared parallel bus with four bus masters. Each master has an active-low request line and receives an active-low grant. The masters are split into two groups. The first group (masters 0 and 1) takes turns. After each full turn of the first group, the second group (masters 2 and 3) gets one slot, and that slot rotates among its members. With all masters asking, the service order is 0, 1, 2, 0, 1, 3, and then it repeats.

Grants can move while the current owner's transfer is still on the bus, so a handover adds no idle arbitration cycles. Once an owner starts a transaction, it keeps its grant for a programmable number of clocks. A transaction start is recognised when `frame_n` falls after a clock in which both `frame_n` and `irdy_n` were high. When nobody asks for the bus, the grant parks. It parks either on a configured master or on the last master that held it.

Top module: `rr2_arbiter`

## Requirements
- R1: While `rst_n` is low, every bit of `gnt_n` is high. In the first clock after reset is released, a grant is issued.
- R2: At most one bit of `gnt_n` is low in any clock.
- R3: A grant never passes directly from one master to another. At least one clock with all of `gnt_n` high lies between two different grantees.
- R4: When masters 0..3 all request, and each grantee runs one short transaction, grants follow the order 0, 1, 2, 0, 1, 3, repeating. Master i is bit i of `req_n` and `gnt_n`.
- R5: A slot whose master does not request is skipped, and the next requesting master in the order is served. With only masters 0 and 3 requesting, the order is 0, 0, 3, repeating.
- R6: With `park_fixed` = 1 and no requests, a free bus is granted to the master numbered `park_master`. A parked grant on any other master is withdrawn.
- R7: With `park_fixed` = 0 and no requests, the current grant stays where it is.
- R8: After a grantee starts a transaction, its grant is held through at least `lat_timer` further clocks. It is withdrawn at the earliest on the (`lat_timer`+1)-th clock after the start.
- R9: The handover to a waiting master completes while `frame_n` is still low from the previous owner's transaction.
- R10: A grantee that has not started a transaction and has dropped its request loses its grant in the next clock when another master requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_n | input | N_MST | Bus requests, active low, bit i from master i |
| frame_n | input | 1 | Bus cycle framing, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| lat_timer | input | LT_W | Minimum tenure in clocks after a transaction start |
| park_fixed | input | 1 | 1: park on `park_master`; 0: park on the last owner |
| park_master | input | $clog2(N_MST) | Master number used for fixed parking |
| gnt_n | output | N_MST | Bus grants, active low, bit i to master i |

## Verification
The checker assumes that masters follow the bus rules. A master drops `frame_n` only while it holds a grant and after the bus has been idle for a clock. `irdy_n` is never low while `frame_n` is high. The tenure property relies on this, because it identifies the owner from the grant in force when `frame_n` falls. The bench respects this assumption: it starts a transfer only when a grant is visible on the outputs and the bus was idle in the clock before. It drives `irdy_n` together with `frame_n`. Random request patterns, tenure values and parking settings are mixed with directed runs for the service order, skipping, both parking modes and a long transfer that forces a hidden handover.

// File: rtl/rr2_arb_pkg.sv
// Shared helpers for the two-level arbiter.
// Assumes group one holds masters 0..g1-1 and group two holds the rest.
package rr2_arb_pkg;

    // Master served by slot k of the repeating service pattern
    function automatic int slot_owner(input int k, input int g1, input int g2);
        int lane;
        lane = k % (g1 + 1);
        if (lane < g1) return lane;
        return g1 + ((k / (g1 + 1)) % g2);
    endfunction

endpackage

// File: rtl/rr2_pick.sv
// Next-winner search over the nested service pattern.
// Walks the pattern from the current position and returns the first
// requesting master, together with the position that follows it.
// Assumes the pattern has (G1_SZ+1)*G2_SZ slots.
module rr2_pick
    import rr2_arb_pkg::*;
#(
    parameter int N_MST = 4,
    parameter int G1_SZ = 2,
    localparam int G2_SZ  = N_MST - G1_SZ,
    localparam int PERIOD = (G1_SZ + 1) * G2_SZ,
    localparam int POS_W  = $clog2(PERIOD),
    localparam int IDX_W  = $clog2(N_MST)
) (
    input  logic [N_MST-1:0] req,
    input  logic [POS_W-1:0] pos,
    output logic             found,
    output logic [IDX_W-1:0] win,
    output logic [POS_W-1:0] nxt
);

    // First requesting master in pattern order, starting at pos
    always_comb begin
        int k;
        int m;
        found = 1'b0;
        win   = '0;
        nxt   = '0;
        for (int i = 0; i < PERIOD; i++) begin
            k = (int'(pos) + i) % PERIOD;
            m = slot_owner(k, G1_SZ, G2_SZ);
            if (!found && req[m]) begin
                found = 1'b1;
                win   = IDX_W'(m);
                nxt   = POS_W'((k + 1) % PERIOD);
            end
        end
    end

endmodule

// File: rtl/rr2_tenure.sv
// Transaction start detection and minimum-tenure countdown.
// A start is a falling frame_n after a clock with frame_n and irdy_n high,
// while a grant is out. The count loads lat and runs down to zero.
module rr2_tenure #(
    parameter int LT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_n,
    input  logic            irdy_n,
    input  logic            gnt_on,
    input  logic [LT_W-1:0] lat,
    output logic            start,
    output logic            expired
);

    logic            frame_q;
    logic            irdy_q;
    logic [LT_W-1:0] tcnt;

    // Start event: bus was idle last clock and a new frame begins now
    always_comb start = gnt_on && frame_q && irdy_q && !frame_n;

    // Tenure has run out when the count sits at zero
    always_comb expired = (tcnt == '0);

    // Bus state history and tenure count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= 1'b1;
            irdy_q  <= 1'b1;
            tcnt    <= '0;
        end else begin
            frame_q <= frame_n;
            irdy_q  <= irdy_n;
            if (start)            tcnt <= lat;
            else if (tcnt != '0)  tcnt <= tcnt - 1'b1;
        end
    end

endmodule

// File: rtl/rr2_arbiter.sv
// Two-level rotating bus arbiter, top level.
// Holds one grant at a time. Withdraws it for one clock before moving it.
// Honours the tenure count and parks when no one asks.
// Assumes masters only start a frame while granted and the bus was idle.
module rr2_arbiter #(
    parameter int N_MST = 4,
    parameter int G1_SZ = 2,
    parameter int LT_W  = 8,
    localparam int IDX_W  = $clog2(N_MST),
    localparam int PERIOD = (G1_SZ + 1) * (N_MST - G1_SZ),
    localparam int POS_W  = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] req_n,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic [LT_W-1:0]  lat_timer,
    input  logic             park_fixed,
    input  logic [IDX_W-1:0] park_master,
    output logic [N_MST-1:0] gnt_n
);

    logic [N_MST-1:0] req;
    logic             gnt_on;
    logic [IDX_W-1:0] cur;
    logic [POS_W-1:0] seq_pos;
    logic             started;
    logic             win_found;
    logic [IDX_W-1:0] win_m;
    logic [POS_W-1:0] win_nxt;
    logic             start_evt;
    logic             expired;
    logic             others;
    logic             park_move;
    logic             release_now;

    // Active-high view of the requests
    always_comb req = ~req_n;

    rr2_pick #(.N_MST(N_MST), .G1_SZ(G1_SZ)) u_pick (
        .req   (req),
        .pos   (seq_pos),
        .found (win_found),
        .win   (win_m),
        .nxt   (win_nxt)
    );

    rr2_tenure #(.LT_W(LT_W)) u_ten (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .gnt_on  (gnt_on),
        .lat     (lat_timer),
        .start   (start_evt),
        .expired (expired)
    );

    // Decide whether the present grant must be withdrawn this clock
    always_comb begin
        others      = |(req & ~(N_MST'(1) << cur));
        park_move   = park_fixed && (req == '0) && (cur != park_master);
        release_now = gnt_on && !start_evt && expired &&
                      (started || !req[cur]) && (others || park_move);
    end

    // Grant state: a one-clock gap, then a new grant or a parked grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_on  <= 1'b0;
            cur     <= '0;
            seq_pos <= '0;
            started <= 1'b0;
        end else if (!gnt_on) begin
            gnt_on  <= 1'b1;
            started <= 1'b0;
            if (win_found) begin
                cur     <= win_m;
                seq_pos <= win_nxt;
            end else if (park_fixed) begin
                cur <= park_master;
            end
        end else begin
            if (start_evt)   started <= 1'b1;
            if (release_now) gnt_on  <= 1'b0;
        end
    end

    // One grant output per master
    for (genvar g = 0; g < N_MST; g++) begin : g_gnt
        assign gnt_n[g] = !(gnt_on && (cur == IDX_W'(g)));
    end

endmodule

// File: rtl/rr2_arb_chk.sv
// Property checker for the two-level arbiter, bound to every instance.
// Tracks the transaction start and tenure on its own, from the ports only.
module rr2_arb_chk #(
    parameter int N_MST = 4,
    parameter int LT_W  = 8,
    localparam int IDX_W = $clog2(N_MST)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_MST-1:0] req_n,
    input logic             frame_n,
    input logic             irdy_n,
    input logic [LT_W-1:0]  lat_timer,
    input logic             park_fixed,
    input logic [IDX_W-1:0] park_master,
    input logic [N_MST-1:0] gnt_n
);

    logic [N_MST-1:0] g;
    logic [N_MST-1:0] prev_g;
    logic             fq;
    logic             iq;
    logic [LT_W-1:0]  ck_cnt;
    logic             ck_start;

    assign g        = ~gnt_n;
    assign ck_start = (g != '0) && fq && iq && !frame_n;

    // Port history and independent tenure count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_g <= '0;
            fq     <= 1'b1;
            iq     <= 1'b1;
            ck_cnt <= '0;
        end else begin
            prev_g <= g;
            fq     <= frame_n;
            iq     <= irdy_n;
            if (ck_start)           ck_cnt <= lat_timer;
            else if (ck_cnt != '0)  ck_cnt <= ck_cnt - 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (gnt_n == '1));

    assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(g));

    assert_gap_on_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((g != '0) && (prev_g != '0)) |-> (g == prev_g));

    assert_fixed_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((g == '0) && (req_n == '1) && park_fixed) |=>
        (g == (N_MST'(1) << $past(park_master))));

    assert_last_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((g != '0) && (req_n == '1) && !park_fixed) |=> $stable(gnt_n));

    assert_tenure_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((g != '0) && (ck_start || (ck_cnt != '0))) |=> $stable(gnt_n));

endmodule

bind rr2_arbiter rr2_arb_chk #(.N_MST(N_MST), .LT_W(LT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_n       (req_n),
    .frame_n     (frame_n),
    .irdy_n      (irdy_n),
    .lat_timer   (lat_timer),
    .park_fixed  (park_fixed),
    .park_master (park_master),
    .gnt_n       (gnt_n)
);

// File: tb/sim_rr2_arbiter.sv
module sim_rr2_arbiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req_n = 4'hF;
    logic       frame_n = 1'b1;
    logic       irdy_n = 1'b1;
    logic [7:0] lat_timer = 8'd0;
    logic       park_fixed = 1'b1;
    logic [1:0] park_master = 2'd2;
    logic [3:0] gnt_n;

    int n_chk = 0;
    int n_fail = 0;

    // Reference state
    bit m_on, m_st, m_fq, m_iq;
    int m_cur, m_pos, m_t;

    always #2.5 clk = ~clk;

    rr2_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n),
        .irdy_n(irdy_n), .lat_timer(lat_timer), .park_fixed(park_fixed),
        .park_master(park_master), .gnt_n(gnt_n)
    );

    function automatic int pat_owner(int k);
        int lane = k % 3;
        if (lane < 2) return lane;
        return 2 + (k / 3) % 2;
    endfunction

    function automatic logic [3:0] exp_gnt();
        return m_on ? ~(4'b1 << m_cur) : 4'hF;
    endfunction

    function automatic int gnt_idx(logic [3:0] gv);
        for (int i = 0; i < 4; i++) if (!gv[i]) return i;
        return -1;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the reference over the coming edge using the applied inputs
    task automatic step();
        logic [3:0] r;
        bit start, found, others, pmove, rel;
        int wm, wn;
        if (!rst_n) begin
            m_on = 0; m_cur = 0; m_pos = 0; m_st = 0; m_t = 0; m_fq = 1; m_iq = 1;
            return;
        end
        r = ~req_n;
        start = m_on && m_fq && m_iq && !frame_n;
        found = 0; wm = 0; wn = 0;
        for (int i = 0; i < 6; i++) begin
            int k = (m_pos + i) % 6;
            if (!found && r[pat_owner(k)]) begin
                found = 1; wm = pat_owner(k); wn = (k + 1) % 6;
            end
        end
        others = (r & ~(4'b1 << m_cur)) != 0;
        pmove = park_fixed && r == 0 && m_cur != int'(park_master);
        rel = m_on && !start && m_t == 0 && (m_st || !r[m_cur]) && (others || pmove);
        if (!m_on) begin
            m_on = 1; m_st = 0;
            if (found) begin m_cur = wm; m_pos = wn; end
            else if (park_fixed) m_cur = int'(park_master);
        end else begin
            if (start) m_st = 1;
            if (rel) m_on = 0;
        end
        if (start) m_t = int'(lat_timer);
        else if (m_t != 0) m_t--;
        m_fq = frame_n; m_iq = irdy_n;
    endtask

    // One clock: reference update, then compare at the falling edge
    task automatic cyc(string tag);
        step();
        @(negedge clk);
        chk(gnt_n == exp_gnt(), tag, gnt_n, exp_gnt());
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc("R1 reset");
        chk(gnt_n == 4'hF, "R1 quiet", gnt_n, 4'hF);
        rst_n = 1'b1;
    endtask

    task automatic wait_grant(output int idx);
        idx = -1;
        for (int n = 0; n < 40 && idx < 0; n++) begin
            cyc("R3 order model");
            idx = gnt_idx(gnt_n);
        end
    endtask

    // Run a pattern of short transfers and compare grantees with a list
    task automatic run_order(logic [3:0] rq, int exp_list[6], string tag);
        int got;
        req_n = ~rq;
        for (int s = 0; s < 6; s++) begin
            wait_grant(got);
            chk(got == exp_list[s], tag, got, exp_list[s]);
            frame_n = 0; irdy_n = 0;
            cyc(tag);
            frame_n = 1; irdy_n = 1;
            for (int n = 0; n < 10 && gnt_n != 4'hF; n++) cyc(tag);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) do_reset();

        // First clock out of reset issues the fixed parking grant (R1, R6)
        cyc("R1 first grant");
        chk(gnt_n == 4'b1011, "R6 park fixed", gnt_n, 4'b1011);
        repeat (2) cyc("R6 hold");
        chk(gnt_n == 4'b1011, "R6 park held", gnt_n, 4'b1011);

        // Idle parked grantee is taken away at once (R10)
        req_n = 4'b1110;
        cyc("R10 drop");
        chk(gnt_n == 4'hF, "R10 released", gnt_n, 4'hF);
        cyc("R10 regrant");
        chk(gnt_n == 4'b1110, "R10 new owner", gnt_n, 4'b1110);

        // Last-owner parking keeps the grant (R7)
        req_n = 4'hF; park_fixed = 1'b0;
        repeat (4) cyc("R7 hold");
        chk(gnt_n == 4'b1110, "R7 park last", gnt_n, 4'b1110);

        // Full service order (R4)
        do_reset();
        run_order(4'hF, '{0, 1, 2, 0, 1, 3}, "R4 order");

        // Skipped slots (R5)
        do_reset();
        run_order(4'b1001, '{0, 0, 3, 0, 0, 3}, "R5 skip");

        // Tenure and hidden handover (R8, R9)
        do_reset();
        lat_timer = 8'd5; req_n = 4'b1110;
        cyc("R8 grant");
        chk(gnt_n == 4'b1110, "R8 first owner", gnt_n, 4'b1110);
        frame_n = 0; irdy_n = 0; req_n = 4'b1100;
        for (int j = 0; j < 6; j++) begin
            cyc("R8 tenure");
            chk(gnt_n == 4'b1110, "R8 held", gnt_n, 4'b1110);
        end
        cyc("R9 release");
        chk(gnt_n == 4'hF && !frame_n, "R9 release busy", gnt_n, 4'hF);
        cyc("R9 handover");
        chk(gnt_n == 4'b1101 && !frame_n, "R9 hidden grant", gnt_n, 4'b1101);
        frame_n = 1; irdy_n = 1; req_n = 4'hF;
        cyc("R9 end");

        // Random traffic against the reference (R2, R3)
        begin
            int busy = 0;
            for (int c = 0; c < 3000; c++) begin
                if (c % 200 == 0) begin
                    lat_timer = 8'($urandom % 4);
                    park_fixed = 1'($urandom);
                    park_master = 2'($urandom);
                end
                if (c % 3 == 0) req_n = 4'($urandom);
                if (frame_n && m_fq && gnt_n != 4'hF && ($urandom % 3 == 0)) begin
                    frame_n = 0; irdy_n = 0; busy = $urandom % 4;
                end else if (!frame_n) begin
                    if (busy == 0) begin frame_n = 1; irdy_n = 1; end
                    else busy--;
                end
                cyc("R3 random");
                chk($countones(~gnt_n) <= 1, "R2 one grant", gnt_n, 0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule